// File: doc/BRIEF.md
# Logarithmic-Depth Two-Operand Adder

This block adds two unsigned operands of a parameterised width W. It returns the low W bits of their sum, so the result wraps modulo 2^W. There is no carry input and no carry output. It is purely combinational: there is no clock, no reset and no state. It is meant to be the final carry-propagate stage after an operand reduction, or any place where a wide add must settle in logarithmic rather than linear gate depth.

The carry logic is an explicit span-doubling prefix tree. Each bit position first forms a local generate (both inputs set) and a local propagate (exactly one input set). Then ceil(log2 W) combining levels follow. Level k merges every position i with position i - 2^(k-1). Positions below that span pass through unchanged. The group propagate is not formed on the last level, because nothing reads it after that. A final XOR layer joins each local propagate with the group carry of the bit below. No arithmetic operator appears in the datapath.

Two widths get their own structure. W = 1 reduces to a single XOR gate. W = 0 builds no logic: the one-bit placeholder output is held at zero. There are no states and no transitions, because the block is combinational.

Top module: `kspa_adder`

## Requirements
- R1: For every pair of inputs, y equals (a + b) mod 2^W.
- R2: The carry out of bit W-1 is discarded: all-ones plus all-ones gives all-ones with bit 0 cleared.
- R3: There is no carry-in: 0 + 0 gives 0, and with b = 0 the output equals a.
- R4: Bit 0 of y always equals a[0] XOR b[0].
- R5: A carry generated at bit 0 reaches the top bit through every prefix level: all-ones plus 1 gives 0.
- R6: A position with both inputs clear stops a carry. With a equal to all-ones except bit m and b = 1, y has bits below m clear, bit m set, and bits above m set.
- R7: When no position has both inputs set (a AND b = 0), y equals a OR b. An example is alternating 0101... plus 1010..., which gives all ones.
- R8: With W = 1, y = a XOR b. With W = 0, the one-bit output y is constant 0.
- R9: Widths that are not powers of two (3, 5, 13), where some positions skip levels, still satisfy R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | max(W,1) | First unsigned operand |
| b | input | max(W,1) | Second unsigned operand |
| y | output | max(W,1) | Sum modulo 2^W (held at 0 when W = 0) |

## Verification
Widths 1, 2, 3, 5 and 8 are swept over every input pair. This shows that each pass-through and combine position of each level is wired to the right neighbour. Widths 13, 32 and 64 get random pairs plus directed patterns. Zero operands show that no carry-in is present. All-ones plus one and all-ones plus all-ones drive a carry through every level and show that the top carry is dropped. A kill bit moved across all positions shows that a carry stops exactly at the first position with both inputs clear. Disjoint alternating bits show that no false carry is generated where none should exist.

// File: rtl/kspa_pkg.sv
package kspa_pkg;

    // Number of span-doubling levels: ceil(log2(w)), 0 for w <= 1.
    function automatic int kspa_levels(input int w);
        int lv;
        lv = 0;
        while ((1 << lv) < w) begin
            lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/kspa_gp_cell.sv
module kspa_gp_cell (
    input  logic a_i,
    input  logic b_i,
    output logic gen_o,
    output logic prop_o
);
    assign gen_o  = a_i & b_i;
    assign prop_o = a_i ^ b_i;
endmodule

// File: rtl/kspa_prefix_level.sv
module kspa_prefix_level #(
    parameter int W    = 8,
    parameter int SPAN = 1,
    parameter bit LAST = 1'b0
) (
    input  logic [W-1:0] g_in,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] g_out,
    output logic [W-1:0] p_out
);
    for (genvar i = 0; i < W; i++) begin : g_pos
        if (i < SPAN) begin : g_pass
            assign g_out[i] = g_in[i];
            if (LAST) begin : g_nop
                assign p_out[i] = 1'b0;
            end else begin : g_keep
                assign p_out[i] = p_in[i];
            end
        end else begin : g_comb
            assign g_out[i] = g_in[i] | (p_in[i] & g_in[i-SPAN]);
            if (LAST) begin : g_nop
                assign p_out[i] = 1'b0;
            end else begin : g_grp
                assign p_out[i] = p_in[i] & p_in[i-SPAN];
            end
        end
    end

    if (LAST) begin : g_sink
        logic p_low_unused;
        assign p_low_unused = ^p_in[SPAN-1:0];
    end
endmodule

// File: rtl/kspa_sum_layer.sv
module kspa_sum_layer #(
    parameter int W = 8
) (
    input  logic [W-1:0] p_bit,
    input  logic [W-1:0] g_grp,
    output logic [W-1:0] sum
);
    assign sum[0] = p_bit[0];
    for (genvar i = 1; i < W; i++) begin : g_sum
        assign sum[i] = p_bit[i] ^ g_grp[i-1];
    end

    logic cout_unused;
    assign cout_unused = g_grp[W-1];
endmodule

// File: rtl/kspa_adder.sv
module kspa_adder #(
    parameter int W = 32
) (
    input  logic [((W < 1) ? 1 : W)-1:0] a,
    input  logic [((W < 1) ? 1 : W)-1:0] b,
    output logic [((W < 1) ? 1 : W)-1:0] y
);
    localparam int LEVELS = kspa_pkg::kspa_levels(W);

    if (W == 0) begin : g_empty
        logic in_unused;
        assign in_unused = a[0] ^ b[0];
        assign y = '0;
    end else if (W == 1) begin : g_single
        assign y = a ^ b;
    end else begin : g_tree
        logic [W-1:0] g_lvl [0:LEVELS];
        logic [W-1:0] p_lvl [0:LEVELS];

        for (genvar i = 0; i < W; i++) begin : g_bit
            kspa_gp_cell u_gp (
                .a_i   (a[i]),
                .b_i   (b[i]),
                .gen_o (g_lvl[0][i]),
                .prop_o(p_lvl[0][i])
            );
        end

        for (genvar k = 1; k <= LEVELS; k++) begin : g_level
            kspa_prefix_level #(
                .W   (W),
                .SPAN(1 << (k - 1)),
                .LAST(k == LEVELS)
            ) u_lvl (
                .g_in (g_lvl[k-1]),
                .p_in (p_lvl[k-1]),
                .g_out(g_lvl[k]),
                .p_out(p_lvl[k])
            );
        end

        logic p_top_unused;
        assign p_top_unused = ^p_lvl[LEVELS];

        kspa_sum_layer #(.W(W)) u_sum (
            .p_bit(p_lvl[0]),
            .g_grp(g_lvl[LEVELS]),
            .sum  (y)
        );
    end
endmodule

// File: rtl/kspa_adder_chk.sv
module kspa_adder_chk #(
    parameter int W = 32
) (
    input logic [((W < 1) ? 1 : W)-1:0] a,
    input logic [((W < 1) ? 1 : W)-1:0] b,
    input logic [((W < 1) ? 1 : W)-1:0] y
);
    localparam int AW = (W < 1) ? 1 : W;

    if (W == 0) begin : g_zero
        always_comb begin
            if (!$isunknown(y))
                a_r8_empty_zero: assert (y == 1'b0);
        end
    end else begin : g_live
        logic [AW:0]   ref_sum;
        logic [AW-1:0] ones;
        assign ref_sum = {1'b0, a} + {1'b0, b};
        assign ones    = '1;

        always_comb begin
            if (!$isunknown({a, b, y})) begin
                a_r1_sum_mod: assert (y == ref_sum[AW-1:0]);
                a_r4_lsb_xor: assert (y[0] == (a[0] ^ b[0]));
                if (b == '0)
                    a_r3_zero_addend: assert (y == a);
                if (a == ones && b == AW'(1))
                    a_r5_full_carry: assert (y == '0);
                if ((a & b) == '0)
                    a_r7_disjoint_bits: assert (y == (a | b));
            end
        end
    end
endmodule

bind kspa_adder kspa_adder_chk #(.W(W)) u_chk (.a(a), .b(b), .y(y));

// File: tb/kspa_adder_test.sv
module kspa_adder_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [0:0]  a0 = '0, b0 = '0;  logic [0:0]  y0;
    logic [0:0]  a1 = '0, b1 = '0;  logic [0:0]  y1;
    logic [1:0]  a2 = '0, b2 = '0;  logic [1:0]  y2;
    logic [2:0]  a3 = '0, b3 = '0;  logic [2:0]  y3;
    logic [4:0]  a5 = '0, b5 = '0;  logic [4:0]  y5;
    logic [7:0]  a8 = '0, b8 = '0;  logic [7:0]  y8;
    logic [12:0] a13 = '0, b13 = '0; logic [12:0] y13;
    logic [31:0] a32 = '0, b32 = '0; logic [31:0] y32;
    logic [63:0] a64 = '0, b64 = '0; logic [63:0] y64;

    kspa_adder #(.W(0))  dut_w0  (.a(a0),  .b(b0),  .y(y0));
    kspa_adder #(.W(1))  dut_w1  (.a(a1),  .b(b1),  .y(y1));
    kspa_adder #(.W(2))  dut_w2  (.a(a2),  .b(b2),  .y(y2));
    kspa_adder #(.W(3))  dut_w3  (.a(a3),  .b(b3),  .y(y3));
    kspa_adder #(.W(5))  dut_w5  (.a(a5),  .b(b5),  .y(y5));
    kspa_adder #(.W(8))  dut_w8  (.a(a8),  .b(b8),  .y(y8));
    kspa_adder #(.W(13)) dut_w13 (.a(a13), .b(b13), .y(y13));
    kspa_adder #(.W(32)) uut     (.a(a32), .b(b32), .y(y32));
    kspa_adder #(.W(64)) dut_w64 (.a(a64), .b(b64), .y(y64));

    typedef struct {
        int          w;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    function automatic logic [63:0] mask_of(input int w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    task automatic drive(input int w, input logic [63:0] av, input logic [63:0] bv,
                         input string tag);
        item_t it;
        @(posedge clk);
        case (w)
            0:  begin a0 = av[0:0];   b0 = bv[0:0];   end
            1:  begin a1 = av[0:0];   b1 = bv[0:0];   end
            2:  begin a2 = av[1:0];   b2 = bv[1:0];   end
            3:  begin a3 = av[2:0];   b3 = bv[2:0];   end
            5:  begin a5 = av[4:0];   b5 = bv[4:0];   end
            8:  begin a8 = av[7:0];   b8 = bv[7:0];   end
            13: begin a13 = av[12:0]; b13 = bv[12:0]; end
            32: begin a32 = av[31:0]; b32 = bv[31:0]; end
            default: begin a64 = av; b64 = bv; end
        endcase
        it.w = w;
        if (w == 0) it.exp = '0;
        else it.exp = ((av & mask_of(w)) + (bv & mask_of(w))) & mask_of(w);
        it.tag = tag;
        q.push_back(it);
    endtask

    function automatic logic [63:0] read_y(input int w);
        case (w)
            0:  return 64'(y0);
            1:  return 64'(y1);
            2:  return 64'(y2);
            3:  return 64'(y3);
            5:  return 64'(y5);
            8:  return 64'(y8);
            13: return 64'(y13);
            32: return 64'(y32);
            default: return y64;
        endcase
    endfunction

    // scoreboard monitor: sample away from the driving edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            logic [63:0] got;
            it = q.pop_front();
            got = read_y(it.w);
            checks++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s W=%0d actual=%h expected=%h", it.tag, it.w, got, it.exp);
            end
        end
    end

    task automatic sweep(input int w, input string tag);
        for (int x = 0; x < (1 << w); x++)
            for (int z = 0; z < (1 << w); z++)
                drive(w, 64'(x), 64'(z), tag);
    endtask

    task automatic directed(input int w);
        logic [63:0] m;
        logic [63:0] alt;
        m = mask_of(w);
        alt = 64'h5555_5555_5555_5555 & m;
        drive(w, 0, 0, "R3 zero plus zero");
        drive(w, 64'h1234_5678_9abc_def0 & m, 0, "R3 b zero passes a");
        drive(w, m, m, "R2 ones plus ones drops carry out");
        drive(w, m, 1, "R5 ones plus one wraps to zero");
        drive(w, alt, ~alt & m, "R7 disjoint alternating bits");
        drive(w, 64'h0f0f_0f0f_0f0f_0f0f & m, 64'hf0f0_f0f0_f0f0_f0f0 & m, "R7 disjoint nibbles");
        for (int k = 0; k < w; k++)
            drive(w, m & ~(64'd1 << k), 1, "R6 kill bit stops carry");
        for (int k = 0; k < 40; k++)
            drive(w, {$urandom, $urandom}, {$urandom, $urandom}, "R4 lsb xor random");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (y32 !== 32'd0 || y0 !== 1'b0) begin
            bad++;
            $display("FAIL R3 idle state actual=%h expected=0", y32);
        end
        sweep(0, "R8 empty width holds zero");
        sweep(1, "R8 single bit xor");
        sweep(2, "R1 exhaustive W2");
        sweep(3, "R9 exhaustive W3");
        sweep(5, "R9 exhaustive W5");
        sweep(8, "R1 exhaustive W8");
        directed(13);
        directed(32);
        directed(64);
        for (int k = 0; k < 2000; k++) begin
            drive(13, 64'($urandom), 64'($urandom), "R9 random W13");
            drive(32, 64'($urandom), 64'($urandom), "R1 random W32");
            drive(64, {$urandom, $urandom}, {$urandom, $urandom}, "R1 random W64");
        end
        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R1 scoreboard left=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule